// File: doc/BRIEF.md
# Watchdog Timer with Pre-Timeout Interrupt

This block guards a system against software that stops making progress. Once enabled, it counts down a programmable number of half-second periods, taking its time base from a single-cycle tick enable supplied from outside. Software keeps the system alive by writing a two-word key sequence to the service register, which reloads the count. If the count runs out, the block pulses its reset output. If software has asked for it, the block also raises a sticky failure output.

An interrupt can be armed to warn software a chosen number of half-second periods before expiry. Software can also pulse the reset output or hold the failure output directly. The block records whether the most recent reset came from power-on, from expiry or from the software request. Counting can be paused while the system is in debug, wait or low-power mode, each with its own enable. After power-on, a separate power-down guard counts 32 ticks and then raises the failure output, unless software turns it off first.

Registers are 16 bits wide and sit at byte offsets 0x0 (control), 0x2 (service), 0x4 (reset cause), 0x6 (interrupt) and 0x8 (miscellaneous). A read returns data in the cycle after the read strobe. A write takes effect at the clock edge that samples it.

Top module: `wdog_timer`

## Requirements
- R1: After reset, all three outputs are low and the registers read control 0x0000, reset cause 0x0001, interrupt 0x0000 and miscellaneous 0x0001.
- R2: Control bits [15:8] hold a field N and bit 0 enables the watchdog. After enable goes from 0 to 1, the reset output is high for exactly one cycle, following the clock edge that samples the (N+1)th tick. The count then reloads from N.
- R3: Writing 0x5555 and then 0xAAAA to the service register reloads the count from N. Any other value written between the two cancels the sequence. The service register reads as 0.
- R4: Control bits 1, 2 and 3 freeze the count while the debug, wait or low-power input, respectively, is high. A mode input whose control bit is clear has no effect on counting.
- R5: When control bit 4 is set, expiry also raises the failure output in the same cycle as the reset pulse, and the failure output stays high until reset. When bit 4 is clear, expiry leaves the failure output low.
- R6: Writing 1 to control bit 5 pulses the reset output for one cycle, following the write edge. The bit reads back as 0.
- R7: Control bit 6 holds the failure output high one cycle after it is written as 1, and lets it fall one cycle after it is written as 0.
- R8: Reset-cause bit 0 marks power-on, bit 1 marks expiry and bit 2 marks the software request. Exactly one of these bits is set at any time: the newest cause sets its own bit and clears the other two.
- R9: The interrupt register holds a lead field L in bits [15:8], enable in bit 0 and status in bit 1. Status is set when a tick brings the count down to L. It stays set until software writes 1 to bit 1. The interrupt output follows status AND enable, one cycle later.
- R10: Miscellaneous bit 0 is 1 after reset. While it is set, the 32nd tick raises the failure output one cycle later, and the output then stays high. Writing 0 clears the bit for good: a later write of 1 is ignored.
- R11: While the enable bit is 0, ticks neither change the count nor produce a reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset, halfword aligned |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| tick_i | input | 1 | Half-second tick enable, one cycle wide |
| dbg_i | input | 1 | System is in debug mode |
| wait_i | input | 1 | System is in wait mode |
| lpm_i | input | 1 | System is in low-power mode |
| wd_rst_o | output | 1 | Reset request pulse |
| wd_fail_o | output | 1 | Failure output |
| wd_irq_o | output | 1 | Pre-timeout interrupt |

## Verification
The assertions assume that reset is held for at least one clock edge and that register accesses use aligned offsets. The count-hold property also assumes that a reload is the only thing that can change the count while counting is frozen. The bench keeps ticks one cycle wide with at least one idle cycle between them, and toggles mode inputs and register writes only between ticks. Under these conditions every tick falls in a known cycle. The randomized part draws timeout values from 2 to 15 and lead values below the timeout, so the interrupt always fires before expiry and the expected cycle can be computed in advance.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int REG_W = 16;
  localparam int TMO_W = 8;

  typedef enum logic [2:0] {
    RI_CTRL = 3'd0,
    RI_SERV = 3'd1,
    RI_CAUSE = 3'd2,
    RI_IRQ  = 3'd3,
    RI_MISC = 3'd4
  } reg_idx_e;

  // control register bit positions
  localparam int C_EN  = 0;
  localparam int C_DBG = 1;
  localparam int C_WT  = 2;
  localparam int C_LP  = 3;
  localparam int C_FOT = 4;
  localparam int C_SWR = 5;
  localparam int C_SWF = 6;

  localparam logic [REG_W-1:0] KEY_A = 16'h5555;
  localparam logic [REG_W-1:0] KEY_B = 16'hAAAA;

  typedef struct packed {
    logic [TMO_W-1:0] tmo;
    logic             swf;
    logic             fot;
    logic             lp_s;
    logic             wt_s;
    logic             dbg_s;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             tmo_hit,
  input  logic             lead_hit,
  output ctrl_t            ctrl,
  output logic [TMO_W-1:0] lead,
  output logic             ien,
  output logic             istat,
  output logic             pd_en,
  output logic             reload,
  output logic             swr_hit,
  output logic [2:0]       cause
);
  localparam int IW = AW - 1;

  logic          acc_ok;
  logic [IW-1:0] idx;
  logic          wr_ctrl, wr_serv, wr_irq, wr_misc, rd_go;
  logic          armed;

  assign acc_ok  = bus_sel && !bus_addr[0];
  assign idx     = bus_addr[AW-1:1];
  assign wr_ctrl = acc_ok && bus_we && idx == IW'(RI_CTRL);
  assign wr_serv = acc_ok && bus_we && idx == IW'(RI_SERV);
  assign wr_irq  = acc_ok && bus_we && idx == IW'(RI_IRQ);
  assign wr_misc = acc_ok && bus_we && idx == IW'(RI_MISC);
  assign rd_go   = acc_ok && !bus_we;
  assign swr_hit = wr_ctrl && bus_wdata[C_SWR];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      lead      <= '0;
      ien       <= 1'b0;
      istat     <= 1'b0;
      pd_en     <= 1'b1;
      cause     <= 3'b001;
      armed     <= 1'b0;
      reload    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      reload <= 1'b0;
      if (wr_ctrl) begin
        ctrl.tmo   <= bus_wdata[15:8];
        ctrl.swf   <= bus_wdata[C_SWF];
        ctrl.fot   <= bus_wdata[C_FOT];
        ctrl.lp_s  <= bus_wdata[C_LP];
        ctrl.wt_s  <= bus_wdata[C_WT];
        ctrl.dbg_s <= bus_wdata[C_DBG];
        ctrl.en    <= bus_wdata[C_EN];
        if (bus_wdata[C_EN] && !ctrl.en) reload <= 1'b1;
      end
      if (wr_serv) begin
        if (bus_wdata == KEY_A) armed <= 1'b1;
        else if (bus_wdata == KEY_B && armed) begin
          reload <= 1'b1;
          armed  <= 1'b0;
        end else armed <= 1'b0;
      end
      if (wr_irq) begin
        lead <= bus_wdata[15:8];
        ien  <= bus_wdata[0];
      end
      if (lead_hit) istat <= 1'b1;
      else if (wr_irq && bus_wdata[1]) istat <= 1'b0;
      if (wr_misc && !bus_wdata[0]) pd_en <= 1'b0;
      if (tmo_hit) cause <= 3'b010;
      else if (swr_hit) cause <= 3'b100;
      if (rd_go) begin
        case (idx)
          IW'(RI_CTRL):  bus_rdata <= {ctrl.tmo, 1'b0, ctrl.swf, 1'b0, ctrl.fot,
                                       ctrl.lp_s, ctrl.wt_s, ctrl.dbg_s, ctrl.en};
          IW'(RI_CAUSE): bus_rdata <= {13'd0, cause};
          IW'(RI_IRQ):   bus_rdata <= {lead, 6'd0, istat, ien};
          IW'(RI_MISC):  bus_rdata <= {15'd0, pd_en};
          default:       bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/wdt_count.sv
`timescale 1ns/1ps
module wdt_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          load,
  input  logic [CW-1:0] tmo_val,
  input  logic [CW-1:0] lead,
  output logic [CW-1:0] cnt,
  output logic          tmo_hit,
  output logic          lead_hit
);
  logic step;

  assign step     = tick && run && !load;
  assign tmo_hit  = step && cnt == '0;
  assign lead_hit = step && cnt != '0 && (cnt - CW'(1)) == lead;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (load)    cnt <= tmo_val;
    else if (step)    cnt <= (cnt == '0) ? tmo_val : cnt - CW'(1);
  end
endmodule

// File: rtl/wdt_pdown.sv
`timescale 1ns/1ps
module wdt_pdown #(
  parameter int PD_TICKS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic arm,
  output logic done
);
  localparam int PW = $clog2(PD_TICKS);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (arm && !done && tick) begin
      if (cnt == PW'(PD_TICKS - 1)) done <= 1'b1;
      else                          cnt  <= cnt + PW'(1);
    end
  end
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int AW       = 4,
  parameter int PD_TICKS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             tick_i,
  input  logic             dbg_i,
  input  logic             wait_i,
  input  logic             lpm_i,
  output logic             wd_rst_o,
  output logic             wd_fail_o,
  output logic             wd_irq_o
);
  ctrl_t            ctrl;
  logic [TMO_W-1:0] lead, cnt;
  logic             ien, istat, pd_en, reload, swr_hit, tmo_hit, lead_hit;
  logic [2:0]       cause;
  logic             pd_done, fail_lat, en, susp;

  assign en   = ctrl.en;
  assign susp = |({lpm_i, wait_i, dbg_i} & {ctrl.lp_s, ctrl.wt_s, ctrl.dbg_s});

  wdt_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmo_hit(tmo_hit), .lead_hit(lead_hit), .ctrl(ctrl), .lead(lead),
    .ien(ien), .istat(istat), .pd_en(pd_en), .reload(reload),
    .swr_hit(swr_hit), .cause(cause)
  );

  wdt_count #(.CW(TMO_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick_i), .run(en && !susp), .load(reload),
    .tmo_val(ctrl.tmo), .lead(lead), .cnt(cnt),
    .tmo_hit(tmo_hit), .lead_hit(lead_hit)
  );

  wdt_pdown #(.PD_TICKS(PD_TICKS)) u_pdown (
    .clk(clk), .rst(rst), .tick(tick_i), .arm(pd_en), .done(pd_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_rst_o  <= 1'b0;
      wd_fail_o <= 1'b0;
      wd_irq_o  <= 1'b0;
      fail_lat  <= 1'b0;
    end else begin
      wd_rst_o  <= tmo_hit || swr_hit;
      if (tmo_hit && ctrl.fot) fail_lat <= 1'b1;
      wd_fail_o <= fail_lat || (tmo_hit && ctrl.fot) || ctrl.swf || pd_done;
      wd_irq_o  <= istat && ien;
    end
  end
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker (
  input logic       clk,
  input logic       rst,
  input logic       wd_rst_o,
  input logic       wd_fail_o,
  input logic       wd_irq_o,
  input logic [2:0] cause,
  input logic [7:0] cnt,
  input logic       en,
  input logic       susp,
  input logic       reload,
  input logic       ien,
  input logic       pd_done
);
  p_cause_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(cause) == 1);

  p_rst_has_cause_r8: assert property (@(posedge clk) disable iff (rst)
    wd_rst_o |-> cause != 3'b001);

  p_hold_count_r4: assert property (@(posedge clk) disable iff (rst)
    ((!en || susp) && !reload) |=> $stable(cnt));

  p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    wd_irq_o |-> $past(ien));

  p_pd_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    pd_done |=> pd_done);

  p_pd_fails_r10: assert property (@(posedge clk) disable iff (rst)
    pd_done |=> wd_fail_o);
endmodule

bind wdog_timer wdt_checker u_chk (
  .clk(clk), .rst(rst), .wd_rst_o(wd_rst_o), .wd_fail_o(wd_fail_o),
  .wd_irq_o(wd_irq_o), .cause(cause), .cnt(cnt), .en(en), .susp(susp),
  .reload(reload), .ien(ien), .pd_done(pd_done)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  localparam logic [3:0] A_CTRL = 4'h0, A_SERV = 4'h2, A_CAUSE = 4'h4,
                         A_IRQ = 4'h6, A_MISC = 4'h8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1, bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        tick_i = 1'b0, dbg_i = 1'b0, wait_i = 1'b0, lpm_i = 1'b0;
  logic        wd_rst_o, wd_fail_o, wd_irq_o;
  int          vec = 0, bad = 0;
  logic [15:0] rv;
  logic        r;

  wdog_timer i_wdog_timer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_i(tick_i), .dbg_i(dbg_i), .wait_i(wait_i), .lpm_i(lpm_i),
    .wd_rst_o(wd_rst_o), .wd_fail_o(wd_fail_o), .wd_irq_o(wd_irq_o)
  );

  function automatic logic [15:0] ctl(input int n, input logic [7:0] bits);
    return {8'(n), bits};
  endfunction

  function automatic logic exp_irq(input logic ie, input int k, input int n, input int l);
    return ie && (k >= n - l);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk); bus_sel = 1'b0; d = bus_rdata;
  endtask

  task automatic tk(output logic ro);
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; ro = wd_rst_o;
  endtask

  task automatic arm(input int n, input logic [7:0] bits);
    wr(A_CTRL, ctl(n, 8'h00));
    wr(A_CTRL, ctl(n, bits | 8'h01));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    do_reset();
    // R1 reset state
    chk("R1 rst_o", 16'(wd_rst_o), 16'd0);
    chk("R1 fail_o", 16'(wd_fail_o), 16'd0);
    chk("R1 irq_o", 16'(wd_irq_o), 16'd0);
    rd(A_CTRL, rv);  chk("R1 ctrl", rv, 16'h0000);
    rd(A_CAUSE, rv); chk("R1 cause", rv, 16'h0001);
    rd(A_IRQ, rv);   chk("R1 irq reg", rv, 16'h0000);
    rd(A_MISC, rv);  chk("R1 misc", rv, 16'h0001);

    // R10 power-down guard; R11 disabled watchdog never resets
    begin
      int seen = 0;
      for (int k = 1; k <= 31; k++) begin tk(r); seen += int'(r); end
      chk("R11 no reset while disabled", 16'(seen), 16'd0);
      chk("R10 fail before 32 ticks", 16'(wd_fail_o), 16'd0);
      tk(r); @(negedge clk);
      chk("R10 fail after 32 ticks", 16'(wd_fail_o), 16'd1);
      repeat (4) @(negedge clk);
      chk("R10 fail sticky", 16'(wd_fail_o), 16'd1);
    end

    do_reset();
    wr(A_MISC, 16'h0000); wr(A_MISC, 16'h0001);
    rd(A_MISC, rv); chk("R10 clear is final", rv, 16'h0000);
    for (int k = 0; k < 40; k++) tk(r);
    chk("R10 no fail when cleared", 16'(wd_fail_o), 16'd0);

    // R2 basic timeout
    arm(5, 8'h00);
    for (int k = 1; k <= 6; k++) begin tk(r); chk("R2 timeout tick", 16'(r), 16'(k == 6)); end
    chk("R5 no fail without bit4", 16'(wd_fail_o), 16'd0);
    @(negedge clk); chk("R2 one-cycle pulse", 16'(wd_rst_o), 16'd0);
    rd(A_CAUSE, rv); chk("R8 cause timeout", rv, 16'h0002);

    // R6 software reset
    wr(A_CTRL, ctl(5, 8'h21));
    chk("R6 pulse", 16'(wd_rst_o), 16'd1);
    @(negedge clk); chk("R6 pulse end", 16'(wd_rst_o), 16'd0);
    rd(A_CTRL, rv);  chk("R6 bit reads 0", rv, ctl(5, 8'h01));
    rd(A_CAUSE, rv); chk("R8 cause sw", rv, 16'h0004);

    // R7 software failure
    wr(A_CTRL, ctl(5, 8'h41)); @(negedge clk);
    chk("R7 fail on", 16'(wd_fail_o), 16'd1);
    wr(A_CTRL, ctl(5, 8'h01)); @(negedge clk);
    chk("R7 fail off", 16'(wd_fail_o), 16'd0);

    // R3 service
    arm(3, 8'h00);
    tk(r); tk(r);
    wr(A_SERV, 16'h5555); wr(A_SERV, 16'hAAAA);
    for (int k = 1; k <= 4; k++) begin tk(r); chk("R3 reload", 16'(r), 16'(k == 4)); end
    arm(3, 8'h00);
    tk(r); tk(r);
    wr(A_SERV, 16'h5555); wr(A_SERV, 16'h1234); wr(A_SERV, 16'hAAAA);
    for (int k = 1; k <= 2; k++) begin tk(r); chk("R3 broken seq", 16'(r), 16'(k == 2)); end
    rd(A_SERV, rv); chk("R3 service reads 0", rv, 16'h0000);

    // R4 suspend modes
    for (int m = 0; m < 3; m++) begin
      int seen = 0;
      arm(2, 8'(1 << (m + 1)));
      dbg_i = (m == 0); wait_i = (m == 1); lpm_i = (m == 2);
      for (int k = 0; k < 6; k++) begin tk(r); seen += int'(r); end
      chk("R4 frozen", 16'(seen), 16'd0);
      dbg_i = 0; wait_i = 0; lpm_i = 0;
      for (int k = 1; k <= 3; k++) begin tk(r); chk("R4 resumes", 16'(r), 16'(k == 3)); end
    end
    arm(2, 8'h00);
    dbg_i = 1; wait_i = 1; lpm_i = 1;
    for (int k = 1; k <= 3; k++) begin tk(r); chk("R4 mode ignored", 16'(r), 16'(k == 3)); end
    dbg_i = 0; wait_i = 0; lpm_i = 0;

    // R9 random pre-timeout interrupt
    for (int it = 0; it < 20; it++) begin
      int n = $urandom_range(2, 15);
      int l = $urandom_range(0, n - 1);
      logic ie = 1'($urandom_range(0, 1));
      wr(A_IRQ, {8'(l), 6'd0, 1'b1, ie});
      arm(n, 8'h00);
      for (int k = 1; k <= n + 1; k++) begin
        tk(r);
        chk("R2 random timeout", 16'(r), 16'(k == n + 1));
        @(negedge clk);
        chk("R9 irq timing", 16'(wd_irq_o), 16'(exp_irq(ie, k, n, l)));
      end
      rd(A_IRQ, rv); chk("R9 status set", rv, {8'(l), 6'd0, 1'b1, ie});
      wr(A_IRQ, {8'(l), 6'd0, 1'b1, ie});
      rd(A_IRQ, rv); chk("R9 status cleared", rv, {8'(l), 6'd0, 1'b0, ie});
      chk("R9 irq low after clear", 16'(wd_irq_o), 16'd0);
    end

    // R5 failure on timeout
    do_reset();
    wr(A_MISC, 16'h0000);
    arm(1, 8'h10);
    tk(r); chk("R5 no early fail", 16'(wd_fail_o), 16'd0);
    tk(r);
    chk("R5 reset pulse", 16'(r), 16'd1);
    chk("R5 fail with reset", 16'(wd_fail_o), 16'd1);
    repeat (3) @(negedge clk);
    chk("R5 fail sticky", 16'(wd_fail_o), 16'd1);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule